// File: doc/BRIEF.md
# Millisecond Real-Time Clock with Coherent Seconds Snapshot

This block keeps wall time as a free-running seconds count plus a sub-second millisecond count. Both counts advance on a one-cycle millisecond tick enable supplied from outside, and they keep counting for as long as the tick keeps arriving. Because of this, the clock can serve as a persistent time base across power-management sleep states.

Software reaches the block through a small read/write register port with byte offsets. Reading the seconds value and the millisecond value as two separate bus reads could tear when a seconds boundary falls between them. Every read of the millisecond register therefore copies the live seconds count into a shadow register in the same cycle that the milliseconds are sampled.

Software reads milliseconds first and the shadow second. It combines them as shadow × MS_PER_SEC + milliseconds. The shadow is one shared register, so two software agents that interleave this pair of reads can overwrite each other's snapshot.

Top module: `rtc_shadow_clock`

## Requirements
- R1: After reset, reads of the live seconds register (offset 0x08), the shadow register (offset 0x0c) and the millisecond register (offset 0x10) all return 0.
- R2: Each clock cycle with `tick_ms` high advances the millisecond count by one. The count stays within 0..MS_PER_SEC-1. With `tick_ms` low and no seconds write, both counts hold.
- R3: A tick while the millisecond count equals MS_PER_SEC-1 sets the millisecond count to 0 and adds one to the seconds count in the same cycle.
- R4: The seconds count is DATA_W bits wide and wraps from all-ones to 0 on a rollover.
- R5: A read of offset 0x10 returns the millisecond count, and it copies the live seconds count into the shadow in the same cycle. If a tick arrives in that same cycle, both values are the ones from before the tick.
- R6: The shadow changes only on a millisecond read. A read of offset 0x0c returns the snapshot even after later seconds rollovers.
- R7: A write to offset 0x08 loads the seconds count with `wdata` and clears the millisecond count to 0. It takes priority over a tick in the same cycle.
- R8: Writes to any offset other than 0x08 have no effect. Reads of unmapped offsets return 0.
- R9: Read data appears on `rdata` in the cycle after `rd_en` is sampled high, and `rdata` holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle millisecond advance enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, registered |

## Verification
The bench builds the block with MS_PER_SEC set to 10, so that several seconds rollovers fit into a few dozen ticks. This brings the millisecond wrap, the increment of seconds and the persistence of the snapshot across rollovers within reach of short vectors. DATA_W stays at 32. The wrap of seconds at 2^32 is reached by writing all-ones and then ticking through one second.

// File: rtl/rtc_shadow_clock.sv
module rtc_shadow_clock #(
  parameter int MS_PER_SEC = 1000,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ms,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int MS_W = (MS_PER_SEC > 1) ? $clog2(MS_PER_SEC) : 1;
  localparam logic [MS_W-1:0]   MS_LAST  = MS_W'(MS_PER_SEC - 1);
  localparam logic [ADDR_W-1:0] OFS_SEC  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFS_SHDW = ADDR_W'(8'h0c);
  localparam logic [ADDR_W-1:0] OFS_MS   = ADDR_W'(8'h10);

  logic [MS_W-1:0]   ms_q;
  logic [DATA_W-1:0] sec_q;
  logic [DATA_W-1:0] shadow_q;

  wire sec_load = wr_en && (addr == OFS_SEC);
  wire ms_read  = rd_en && (addr == OFS_MS);
  wire ms_wrap  = tick_ms && (ms_q == MS_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ms_q  <= '0;
      sec_q <= '0;
    end else if (sec_load) begin
      ms_q  <= '0;
      sec_q <= wdata;
    end else if (ms_wrap) begin
      ms_q  <= '0;
      sec_q <= sec_q + 1'b1;
    end else if (tick_ms) begin
      ms_q  <= ms_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      shadow_q <= '0;
    else if (ms_read)
      shadow_q <= sec_q;
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    case (addr)
      OFS_SEC:  rd_mux = sec_q;
      OFS_SHDW: rd_mux = shadow_q;
      OFS_MS:   rd_mux = DATA_W'(ms_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata <= '0;
    else if (rd_en)
      rdata <= rd_mux;
  end
endmodule

// File: rtl/rtc_shadow_clock_chk.sv
module rtc_shadow_clock_chk #(
  parameter int MS_PER_SEC = 1000,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int MS_W       = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_ms,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [MS_W-1:0]   ms_q,
  input logic [DATA_W-1:0] sec_q,
  input logic [DATA_W-1:0] shadow_q
);
  wire wr_sec = wr_en && (addr == ADDR_W'(8'h08));
  wire rd_ms  = rd_en && (addr == ADDR_W'(8'h10));

  p_ms_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ms_q) < MS_PER_SEC);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_ms && !wr_sec) |=> ($stable(ms_q) && $stable(sec_q)));

  p_rollover_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_ms && !wr_sec && 32'(ms_q) == MS_PER_SEC - 1)
      |=> (ms_q == '0 && sec_q == $past(sec_q) + 1'b1));

  p_snapshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ms |=> (shadow_q == $past(sec_q)));

  p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ms |=> $stable(shadow_q));

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sec |=> (sec_q == $past(wdata) && ms_q == '0));
endmodule

bind rtc_shadow_clock rtc_shadow_clock_chk #(
  .MS_PER_SEC(MS_PER_SEC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MS_W(MS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .ms_q(ms_q), .sec_q(sec_q), .shadow_q(shadow_q)
);

// File: tb/rtc_shadow_clock_bench.sv
module rtc_shadow_clock_bench;
  localparam int MSP = 10;
  logic clk = 0, rst_n = 0, tick_ms = 0, wr_en = 0, rd_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata, got;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  rtc_shadow_clock #(.MS_PER_SEC(MSP), .DATA_W(32), .ADDR_W(8)) u_rtc_shadow_clock (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata));

  // {ticks[15:0], expected ms[7:0], expected seconds[31:0]}, cumulative
  localparam logic [55:0] VEC [6] = '{
    {16'd3,  8'd3, 32'd0}, {16'd7,  8'd0, 32'd1}, {16'd9, 8'd9, 32'd1},
    {16'd1,  8'd0, 32'd2}, {16'd25, 8'd5, 32'd4}, {16'd5, 8'd0, 32'd5}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tick_ms = 1;
      repeat (n) @(negedge clk);
      tick_ms = 0;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 rdata", rdata, 0);
    rd(8'h08, got); check("R1 seconds", got, 0);
    rd(8'h0c, got); check("R1 shadow", got, 0);
    rd(8'h10, got); check("R1 ms", got, 0);

    for (int i = 0; i < 6; i++) begin
      ticks(int'(VEC[i][55:40]));
      rd(8'h10, got); check("R2/R3 ms", got, 32'(VEC[i][39:32]));
      rd(8'h0c, got); check("R5 shadow", got, VEC[i][31:0]);
      rd(8'h08, got); check("R3 seconds", got, VEC[i][31:0]);
    end

    // R9: rdata holds without a read
    repeat (3) @(negedge clk);
    check("R9 hold", rdata, 5);

    // R2: no ticks -> counts hold
    repeat (5) @(negedge clk);
    rd(8'h10, got); check("R2 idle ms", got, 0);

    // R6: snapshot survives rollovers
    ticks(4);
    rd(8'h10, got); check("R6 ms", got, 4);
    ticks(20);
    rd(8'h0c, got); check("R6 shadow held", got, 5);
    rd(8'h08, got); check("R6 live", got, 7);

    // R5: tick and ms read in the same cycle
    wr(8'h08, 32'd100);
    ticks(9);
    @(negedge clk); tick_ms = 1; rd_en = 1; addr = 8'h10;
    @(negedge clk); tick_ms = 0; rd_en = 0; got = rdata;
    check("R5 coherent ms", got, 9);
    rd(8'h0c, got); check("R5 coherent shadow", got, 100);
    rd(8'h08, got); check("R5 live after", got, 101);

    // R7: write clears ms, wins over tick
    ticks(3);
    @(negedge clk); tick_ms = 1; wr_en = 1; addr = 8'h08; wdata = 32'd42;
    @(negedge clk); tick_ms = 0; wr_en = 0;
    rd(8'h10, got); check("R7 ms cleared", got, 0);
    rd(8'h08, got); check("R7 seconds loaded", got, 42);

    // R4: seconds wrap
    wr(8'h08, 32'hFFFF_FFFF);
    ticks(MSP);
    rd(8'h08, got); check("R4 wrap", got, 0);

    // R8: ignored writes, unmapped read
    ticks(2);
    wr(8'h0c, 32'h1234);
    wr(8'h10, 32'h7);
    wr(8'h00, 32'h55);
    rd(8'h10, got); check("R8 ms untouched", got, 2);
    rd(8'h0c, got); check("R8 shadow untouched", got, 0);
    rd(8'h08, got); check("R8 seconds untouched", got, 0);
    rd(8'h00, got); check("R8 unmapped", got, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule